// File: doc/BRIEF.md
# Resonant Bridge Gate Sequencer

This block drives the eight gates of an isolated resonant DC-DC stage. The stage has a primary full bridge with two legs, A (S1 over S2) and B (S3 over S4). Its secondary is a center-tapped bridge with two legs, and each leg is an anti-series pair made of a P device and an N device. A host loads three timing words: the period, the end of the driving interval (t1) and the current-zero instant (t2). From these the block steps through six stages per period, three in each half. Leg B toggles once per half period. Leg A is phase-shifted from leg B by t1. The conducting secondary leg follows the half period, and a synchronous-rectifier gate on the other device of that leg opens a dead time late and closes a programmable margin before the current-zero instant.

The block has two timing modes. In fixed-period mode the host's period word is used as it stands. In boundary-conduction mode the period is taken as 2·t2, so the two zero-current hold stages shrink to nothing. A timing set is first checked. If it is valid, it is held in a pending copy and is only applied at a period boundary, or while the block is disabled. An invalid set is rejected and raises an error flag. The output gates are registered.

Top module: `rbridge_gate_seq`

## Requirements
- R1: While rst_ni is low, every gate output and cfg_err_o are 0. After reset, the active set is the parameter defaults (DEF_PERIOD, DEF_T1, DEF_T2), in fixed-period mode with positive polarity.
- R2: At the first clock edge that samples en_i low, all gate outputs go to 0 and the position counter returns to 0. When the block is re-enabled it restarts at stage 1: S1 and S4 (pri_gate_o bits 0 and 3) come on after the dead time.
- R3: The position counter c runs from 0 to P-1, where P is the active period, and h = floor(P/2). In the first half (c < h), S1 (bit 0) is requested while c < t1. In the second half, S1 is requested while c-h >= t1. S2 (bit 1) is requested whenever S1 is not. Each output reflects the position one clock later.
- R4: S4 (bit 3) is requested during the first half and S3 (bit 2) during the second half.
- R5: A primary gate turns on only after its request has been held for DEAD_CYC further clocks, and it turns off in the same cycle its request drops. S1 and S2 are never on together, and neither are S3 and S4.
- R6: The main secondary gate of leg 1 (index 0) is on for the first half and the main gate of leg 2 (index 1) for the second half. With pol_neg_i = 0 the main gates are sec_p_o. With pol_neg_i = 1 they are sec_n_o. The two legs are never active at the same time.
- R7: The rectifier gate of a leg is the other device of that leg. It is requested while the leg conducts and (c - start of the half) + sr_margin_i < t2. It is delayed by DEAD_CYC like the primary gates, and it never comes on if sr_margin_i >= t2.
- R8: With bcm_i = 1 the period is 2·t2, and period_i has no effect.
- R9: A valid set (period, t1, t2, polarity, mode) loaded by load_i takes effect only at a period boundary, or while en_i is low. Until then the gates follow the previous set.
- R10: A set is invalid if t2 = 0, if t1 > t2, or if bcm_i = 0 and 2·t2 > period_i. An invalid set is discarded and cfg_err_o reads 1 from the next clock. A valid load clears cfg_err_o. Without a load, cfg_err_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces all gates off |
| load_i | input | 1 | Capture the timing set on the inputs |
| period_i | input | CNT_W | Period in clocks (fixed-period mode) |
| t1_i | input | CNT_W | End of the driving stage, in clocks from the start of the half |
| t2_i | input | CNT_W | Current-zero instant, in clocks from the start of the half |
| pol_neg_i | input | 1 | 1 selects negative output polarity |
| bcm_i | input | 1 | 1 selects boundary-conduction mode (period = 2·t2) |
| sr_margin_i | input | CNT_W | Early release of the rectifier gates, in clocks |
| pri_gate_o | output | 4 | Primary gates S1..S4 at bits 0..3 |
| sec_p_o | output | 2 | P-device gates of secondary legs 1 and 2 |
| sec_n_o | output | 2 | N-device gates of secondary legs 1 and 2 |
| cfg_err_o | output | 1 | The last loaded set was rejected |

## Verification
The assertions check, on every cycle, that the complementary primary switches never overlap and that each primary turn-on follows an off cycle of its partner. They also check that the two secondary legs are never active together, that disabling clears every gate on the next edge, and that the error flag moves only after a load. The exact stage edges cannot be seen one cycle at a time; only the bench's scenarios show them. These include the placement of t1 and t2 inside each half, the length of the dead time and the rectifier's early release, when a new set is applied, the period taken from t2 in boundary mode, and the fact that a rejected set leaves the running pattern untouched.

// File: rtl/rbgs_pkg.sv
package rbgs_pkg;
  // request/delay lane indices
  localparam int unsigned G_S1  = 0;
  localparam int unsigned G_S2  = 1;
  localparam int unsigned G_S3  = 2;
  localparam int unsigned G_S4  = 3;
  localparam int unsigned G_SR1 = 4;
  localparam int unsigned G_SR2 = 5;
  localparam int unsigned N_DLY = 6;

  function automatic logic set_ok(int unsigned per, int unsigned t1,
                                  int unsigned t2, logic bcm);
    if (t2 == 0) return 1'b0;
    if (t1 > t2) return 1'b0;
    if (!bcm && (2 * t2 > per)) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/rbgs_shadow.sv
module rbgs_shadow
  import rbgs_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_PERIOD = 1320,
  parameter int unsigned DEF_T1     = 300,
  parameter int unsigned DEF_T2     = 600
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             apply_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic             neg_i,
  input  logic             bcm_i,
  output logic [CNT_W:0]   per_o,
  output logic [CNT_W-1:0] t1_o,
  output logic [CNT_W-1:0] t2_o,
  output logic             neg_o,
  output logic             err_o
);
  localparam int unsigned PER_W = CNT_W + 1;

  logic [PER_W-1:0] pnd_per, new_per;
  logic [CNT_W-1:0] pnd_t1, pnd_t2;
  logic             pnd_neg, ok;

  assign ok      = set_ok(32'(period_i), 32'(t1_i), 32'(t2_i), bcm_i);
  // boundary mode: period follows the current-zero instant
  assign new_per = bcm_i ? {t2_i, 1'b0} : {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pnd_per <= PER_W'(DEF_PERIOD);
      pnd_t1  <= CNT_W'(DEF_T1);
      pnd_t2  <= CNT_W'(DEF_T2);
      pnd_neg <= 1'b0;
      per_o   <= PER_W'(DEF_PERIOD);
      t1_o    <= CNT_W'(DEF_T1);
      t2_o    <= CNT_W'(DEF_T2);
      neg_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      if (apply_i) begin
        per_o <= pnd_per;
        t1_o  <= pnd_t1;
        t2_o  <= pnd_t2;
        neg_o <= pnd_neg;
      end
      if (load_i) begin
        err_o <= !ok;
        if (ok) begin
          pnd_per <= new_per;
          pnd_t1  <= t1_i;
          pnd_t2  <= t2_i;
          pnd_neg <= neg_i;
        end
      end
    end
  end
endmodule

// File: rtl/rbgs_timer.sv
module rbgs_timer
  import rbgs_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W:0]   per_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic [CNT_W-1:0] margin_i,
  output logic             wrap_o,
  output logic             sec_o,
  output logic [N_DLY-1:0] raw_o
);
  localparam int unsigned PER_W = CNT_W + 1;

  logic [PER_W-1:0] cnt_q, half, loc;
  logic             lead_in, win;

  assign half    = per_i >> 1;
  assign sec_o   = cnt_q >= half;
  assign loc     = sec_o ? cnt_q - half : cnt_q;
  assign lead_in = loc < {1'b0, t1_i};
  // rectifier window closes margin clocks ahead of current zero
  assign win     = ({1'b0, loc} + {2'b0, margin_i}) < {2'b0, t2_i};
  assign wrap_o  = cnt_q >= per_i - 1'b1;

  always_comb begin
    raw_o        = '0;
    raw_o[G_S1]  = sec_o ? !lead_in : lead_in;
    raw_o[G_S2]  = sec_o ? lead_in : !lead_in;
    raw_o[G_S3]  = sec_o;
    raw_o[G_S4]  = !sec_o;
    raw_o[G_SR1] = !sec_o && win;
    raw_o[G_SR2] = sec_o && win;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || wrap_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rbgs_ondelay.sv
module rbgs_ondelay #(
  parameter int unsigned DEAD_CYC = 132
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  output logic on_o
);
  localparam int unsigned DW = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;

  if (DEAD_CYC == 0) begin : g_pass
    assign on_o = raw_i;
  end else begin : g_cnt
    logic [DW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cnt_q <= '0;
      else if (!en_i || !raw_i)         cnt_q <= '0;
      else if (cnt_q != DW'(DEAD_CYC))  cnt_q <= cnt_q + 1'b1;
    end
    assign on_o = raw_i && (cnt_q == DW'(DEAD_CYC));
  end
endmodule

// File: rtl/rbridge_gate_seq.sv
module rbridge_gate_seq
  import rbgs_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEAD_CYC   = 132,
  parameter int unsigned DEF_PERIOD = 1320,
  parameter int unsigned DEF_T1     = 300,
  parameter int unsigned DEF_T2     = 600
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic             pol_neg_i,
  input  logic             bcm_i,
  input  logic [CNT_W-1:0] sr_margin_i,
  output logic [3:0]       pri_gate_o,
  output logic [1:0]       sec_p_o,
  output logic [1:0]       sec_n_o,
  output logic             cfg_err_o
);
  localparam int unsigned PER_W = CNT_W + 1;

  logic [PER_W-1:0] act_per;
  logic [CNT_W-1:0] act_t1, act_t2;
  logic             act_neg, wrap, sec, apply;
  logic [N_DLY-1:0] raw, dly_on;
  logic [1:0]       main_g, sr_g;

  assign apply = !en_i || wrap;

  rbgs_shadow #(
    .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD), .DEF_T1(DEF_T1), .DEF_T2(DEF_T2)
  ) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .apply_i  (apply),
    .period_i (period_i),
    .t1_i     (t1_i),
    .t2_i     (t2_i),
    .neg_i    (pol_neg_i),
    .bcm_i    (bcm_i),
    .per_o    (act_per),
    .t1_o     (act_t1),
    .t2_o     (act_t2),
    .neg_o    (act_neg),
    .err_o    (cfg_err_o)
  );

  rbgs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .per_i    (act_per),
    .t1_i     (act_t1),
    .t2_i     (act_t2),
    .margin_i (sr_margin_i),
    .wrap_o   (wrap),
    .sec_o    (sec),
    .raw_o    (raw)
  );

  for (genvar g = 0; g < N_DLY; g++) begin : g_dly
    rbgs_ondelay #(.DEAD_CYC(DEAD_CYC)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .raw_i  (raw[g]),
      .on_o   (dly_on[g])
    );
  end

  assign main_g = {sec, !sec};
  assign sr_g   = {dly_on[G_SR2], dly_on[G_SR1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_gate_o <= '0;
      sec_p_o    <= '0;
      sec_n_o    <= '0;
    end else if (!en_i) begin
      pri_gate_o <= '0;
      sec_p_o    <= '0;
      sec_n_o    <= '0;
    end else begin
      pri_gate_o <= {dly_on[G_S4], dly_on[G_S3], dly_on[G_S2], dly_on[G_S1]};
      sec_p_o    <= act_neg ? sr_g : main_g;
      sec_n_o    <= act_neg ? main_g : sr_g;
    end
  end
endmodule

// File: rtl/rbgs_chk.sv
module rbgs_chk #(
  parameter int unsigned DEAD_CYC = 132
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       load_i,
  input logic [3:0] pri_gate_o,
  input logic [1:0] sec_p_o,
  input logic [1:0] sec_n_o,
  input logic       cfg_err_o
);
  p_leg_a_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pri_gate_o[0] && pri_gate_o[1]));
  p_leg_b_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pri_gate_o[2] && pri_gate_o[3]));
  p_dead_s2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEAD_CYC > 0 && $rose(pri_gate_o[1])) |-> !$past(pri_gate_o[0]));
  p_dead_s1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEAD_CYC > 0 && $rose(pri_gate_o[0])) |-> !$past(pri_gate_o[1]));
  p_dead_s3_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEAD_CYC > 0 && $rose(pri_gate_o[2])) |-> !$past(pri_gate_o[3]));
  p_dead_s4_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEAD_CYC > 0 && $rose(pri_gate_o[3])) |-> !$past(pri_gate_o[2]));
  p_legs_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((sec_p_o[0] || sec_n_o[0]) && (sec_p_o[1] || sec_n_o[1])));
  p_disable_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pri_gate_o == 4'b0 && sec_p_o == 2'b0 && sec_n_o == 2'b0));
  p_err_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_err_o));
endmodule

bind rbridge_gate_seq rbgs_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .load_i     (load_i),
  .pri_gate_o (pri_gate_o),
  .sec_p_o    (sec_p_o),
  .sec_n_o    (sec_n_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/rbridge_gate_seq_tb.sv
module rbridge_gate_seq_tb;
  localparam int CW = 12;
  localparam int DT = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_r = 1'b0, load_r = 1'b0, neg_r = 1'b0, bcm_r = 1'b0;
  logic [CW-1:0] per_r = '0, t1_r = '0, t2_r = '0, margin_r = '0;
  logic [3:0]    pri_gate_o;
  logic [1:0]    sec_p_o, sec_n_o;
  logic          cfg_err_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  rbridge_gate_seq #(
    .CNT_W(CW), .DEAD_CYC(DT), .DEF_PERIOD(100), .DEF_T1(20), .DEF_T2(40)
  ) u_dut (
    .clk_i, .rst_ni,
    .en_i(en_r), .load_i(load_r), .period_i(per_r), .t1_i(t1_r), .t2_i(t2_r),
    .pol_neg_i(neg_r), .bcm_i(bcm_r), .sr_margin_i(margin_r),
    .pri_gate_o, .sec_p_o, .sec_n_o, .cfg_err_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model, pushes expected per-cycle items ----------------
  typedef logic [8:0] exp_t;
  exp_t sb_q[$];
  int m_cnt, m_per, m_t1, m_t2, p_per, p_t1, p_t2;
  bit m_neg, p_neg, m_err;
  int m_dc[6];

  always @(posedge clk_i or negedge rst_ni) begin : ref_model
    int h, loc, np;
    bit sec, lead, win, wrap, ok;
    bit [5:0] raw, on;
    bit [1:0] main_g, sr_g, sp, sn;
    bit [3:0] pri;
    if (!rst_ni) begin
      // R1: defaults after reset
      m_cnt = 0; m_per = 100; m_t1 = 20; m_t2 = 40; m_neg = 0;
      p_per = 100; p_t1 = 20; p_t2 = 40; p_neg = 0; m_err = 0;
      for (int i = 0; i < 6; i++) m_dc[i] = 0;
      sb_q.delete();
    end else begin
      h = m_per / 2;
      sec = m_cnt >= h;
      loc = sec ? m_cnt - h : m_cnt;
      lead = loc < m_t1;
      win = (loc + int'(margin_r)) < m_t2;            // R7
      raw[0] = sec ? !lead : lead;                     // R3
      raw[1] = !raw[0];
      raw[2] = sec;                                    // R4
      raw[3] = !sec;
      raw[4] = !sec && win;
      raw[5] = sec && win;
      for (int i = 0; i < 6; i++) on[i] = raw[i] && (m_dc[i] >= DT);  // R5
      main_g = {sec, !sec};                            // R6
      sr_g = on[5:4];
      sp = m_neg ? sr_g : main_g;
      sn = m_neg ? main_g : sr_g;
      pri = on[3:0];
      if (!en_r) begin pri = 0; sp = 0; sn = 0; end    // R2
      for (int i = 0; i < 6; i++)
        m_dc[i] = (!en_r || !raw[i]) ? 0 : ((m_dc[i] < DT) ? m_dc[i] + 1 : m_dc[i]);
      wrap = m_cnt >= m_per - 1;
      m_cnt = (!en_r || wrap) ? 0 : m_cnt + 1;
      if (!en_r || wrap) begin                         // R9: apply only at boundary
        m_per = p_per; m_t1 = p_t1; m_t2 = p_t2; m_neg = p_neg;
      end
      if (load_r) begin                                // R10 validity, R8 period from t2
        ok = (t2_r != 0) && (t1_r <= t2_r) && (bcm_r || (2 * int'(t2_r) <= int'(per_r)));
        m_err = !ok;
        if (ok) begin
          np = bcm_r ? 2 * int'(t2_r) : int'(per_r);
          p_per = np; p_t1 = int'(t1_r); p_t2 = int'(t2_r); p_neg = neg_r;
        end
      end
      sb_q.push_back({m_err, sn, sp, pri});
    end
  end

  // ---------------- monitor ----------------
  always @(negedge clk_i) begin : monitor
    exp_t e, a;
    string req;
    if (rst_ni && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      a = {cfg_err_o, sec_n_o, sec_p_o, pri_gate_o};
      if (a[3:0] != e[3:0])      req = "R3 R4 R5 primary";
      else if (a[7:4] != e[7:4]) req = "R6 R7 secondary";
      else                       req = "R10 cfg_err";
      chk(a == e, req, int'(a), int'(e));
    end
  end

  task automatic load_set(input int per, input int t1, input int t2, input bit neg, input bit bcm);
    @(negedge clk_i);
    per_r = CW'(per); t1_r = CW'(t1); t2_r = CW'(t2); neg_r = neg; bcm_r = bcm; load_r = 1'b1;
    @(negedge clk_i);
    load_r = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin : main
    int sr_seen;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(pri_gate_o == 4'b0, "R1 pri", int'(pri_gate_o), 0);
    chk(sec_p_o == 2'b0, "R1 sec_p", int'(sec_p_o), 0);
    chk(sec_n_o == 2'b0, "R1 sec_n", int'(sec_n_o), 0);
    chk(cfg_err_o == 1'b0, "R1 cfg_err", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    margin_r = CW'(3);
    @(negedge clk_i);
    en_r = 1'b1;
    run(300);                       // defaults, R3 R4 R5 R6 R7
    load_set(80, 10, 30, 0, 0);     // mid-period load, R9
    run(250);
    load_set(91, 25, 44, 1, 0);     // odd period, negative polarity, R6
    run(300);
    load_set(7, 15, 35, 0, 1);      // R8: period_i ignored in boundary mode
    run(300);
    load_set(100, 40, 30, 0, 1);    // R10: t1 > t2
    chk(cfg_err_o == 1'b1, "R10 t1>t2", int'(cfg_err_o), 1);
    run(50);
    load_set(50, 10, 30, 0, 0);     // R10: 2*t2 > period
    chk(cfg_err_o == 1'b1, "R10 2t2>T", int'(cfg_err_o), 1);
    run(50);
    load_set(100, 0, 0, 0, 0);      // R10: t2 = 0
    chk(cfg_err_o == 1'b1, "R10 t2=0", int'(cfg_err_o), 1);
    run(50);
    load_set(60, 12, 25, 0, 0);
    chk(cfg_err_o == 1'b0, "R10 valid clears", int'(cfg_err_o), 0);
    run(200);
    margin_r = CW'(30);             // R7: margin >= t2, no rectifier gate
    sr_seen = 0;
    repeat (150) begin
      @(negedge clk_i);
      if (sec_n_o != 2'b0) sr_seen++;
    end
    chk(sr_seen == 0, "R7 margin>=t2", sr_seen, 0);
    margin_r = CW'(2);
    load_set(60, 0, 25, 0, 0);      // t1 = 0 corner
    run(150);
    load_set(60, 12, 25, 0, 0);
    run(150);
    @(negedge clk_i);
    en_r = 1'b0;
    @(negedge clk_i);               // R2: off after one edge
    chk({pri_gate_o, sec_p_o, sec_n_o} == 8'b0, "R2 disable", int'({pri_gate_o, sec_p_o, sec_n_o}), 0);
    run(20);
    chk({pri_gate_o, sec_p_o, sec_n_o} == 8'b0, "R2 held off", int'({pri_gate_o, sec_p_o, sec_n_o}), 0);
    en_r = 1'b1;
    run(5);
    chk(pri_gate_o == 4'b0000, "R5 dead time after enable", int'(pri_gate_o), 0);
    run(1);
    chk(pri_gate_o == 4'b1001, "R2 restart at stage 1", int'(pri_gate_o), 9);
    run(200);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule